// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a watchdog for a single processor core. Once it is configured with a nonzero mode, a prescaler produces one tick every N clock cycles, and each tick decrements a wide down-counter. When the counter is ticked at zero, that is one expiry. The counter then reloads and starts the next period. Each expiry moves the block one step further along a ladder. The first step is an interrupt, the second a non-maskable interrupt, and the third a request for a chip-wide soft reset.

Software programs a 16-bit length and a 2-bit mode through a single write port. The length becomes the upper bits of the down-counter, and the low bits reload as zero. Software keeps the core alive by pulsing the poke input, which reloads the counter and takes the ladder back to its start. The live count can be read at all times, so software can see how much time is left before the next step. The mode sets how far the ladder may climb, and mode zero stops the timer.

Top module: `wdg_escalator`

## Requirements
- R1: While reset is held, the count reads zero and the interrupt, NMI and soft-reset outputs are all low.
- R2: A configuration write loads the count with the written length shifted left by LOW_W bits, with the low bits zero. The new count is readable in the cycle after the write edge, for any mode.
- R3: While enabled, the count changes only once every N = 2^DIV_LOG2 cycles. After a write or poke it holds for N cycles and then drops by one. When ticked at zero it reloads. One period therefore lasts (length*2^LOW_W + 1)*N cycles.
- R4: The first expiry after a write or poke raises the interrupt output for exactly one cycle. That cycle is the one after the edge that comes one period after the write or poke edge. The interrupt does not repeat until the next write or poke.
- R5: When the mode allows it, the second expiry raises the NMI output, and NMI stays high.
- R6: In mode 3, the third expiry raises the soft-reset request, and it stays high. The soft-reset request is never high without NMI.
- R7: The mode value is the number of stages allowed. In mode 1, NMI and soft reset never assert. In mode 2, soft reset never asserts.
- R8: A poke lowers NMI and soft reset and reloads the count from the stored length. It also restarts the prescaler, so that a full period elapses before the next interrupt.
- R9: In mode 0 the timer is disabled. The count stays frozen at its reloaded value and no output asserts, whether or not poke is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Strobe that writes length and mode |
| cfg_len | input | LEN_W (16) | Length; forms the top bits of the counter reload |
| cfg_mode | input | 2 | 0 disabled, 1 interrupt only, 2 up to NMI, 3 up to soft reset |
| poke | input | 1 | Service strobe: reload and clear escalation |
| cnt_o | output | LEN_W+LOW_W (24) | Live down-counter value |
| irq_o | output | 1 | One-cycle interrupt pulse at the first expiry |
| nmi_o | output | 1 | Held NMI after the second expiry |
| srst_o | output | 1 | Held soft-reset request after the third expiry |

## Verification
The main function is run over a range of lengths (0, 1 and 3) and all four modes, sampling at chosen cycle offsets from the write. The offsets just before and at a tick separate a correct prescaler from one that is off by a cycle. The offsets at and just after one period separate a pulsed interrupt from a held one. Multiples of the period tell the three stages apart and show whether each mode's cap is obeyed. A poke given after the ladder has reached the top, and a poke given while the timer is disabled, show that servicing clears held events and restarts the prescaler, and that a disabled timer stays silent.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_IRQ  = 2'd1,
    STG_NMI  = 2'd2,
    STG_RST  = 2'd3
  } wdg_stage_e;

  // Highest stage a mode may reach: the mode value equals the stage count.
  function automatic logic [1:0] stage_cap(input logic [1:0] mode);
    return mode;
  endfunction

  // Stage after one expiry, saturating at the cap of the mode.
  function automatic wdg_stage_e next_stage(input wdg_stage_e cur,
                                            input logic [1:0] mode);
    logic [1:0] cur_v;
    cur_v = cur;
    if (cur_v < stage_cap(mode)) return wdg_stage_e'(cur_v + 2'd1);
    return cur;
  endfunction

  function automatic logic mode_enabled(input logic [1:0] mode);
    return mode != 2'd0;
  endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign tick = run && !restart;
    end else begin : g_div
      logic [DIV_LOG2-1:0] pre_q;

      assign tick = run && !restart && (&pre_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (run)     pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [LEN_W-1:0]       src_len,
  input  logic                   tick,
  output logic [LEN_W+LOW_W-1:0] cnt,
  output logic                   expire
);
  localparam int CNT_W = LEN_W + LOW_W;

  function automatic logic [CNT_W-1:0] reload_of(input logic [LEN_W-1:0] len);
    return {len, {LOW_W{1'b0}}};
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == '0);
  assign cnt    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= reload_of(src_len);
    else if (expire) cnt_q <= reload_of(src_len);
    else if (tick)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       expire,
  input  logic [1:0] mode,
  output wdg_stage_e stage,
  output logic       irq_pulse
);
  wdg_stage_e stage_q, stage_d;
  logic       irq_d;

  always_comb begin
    stage_d = stage_q;
    if (clear)       stage_d = STG_IDLE;
    else if (expire) stage_d = next_stage(stage_q, mode);
  end

  assign irq_d = !clear && expire && (stage_q == STG_IDLE) && mode_enabled(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= STG_IDLE;
      irq_pulse <= 1'b0;
    end else begin
      stage_q   <= stage_d;
      irq_pulse <= irq_d;
    end
  end

  assign stage = stage_q;
endmodule

// File: rtl/wdg_escalator.sv
module wdg_escalator
  import wdg_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int LOW_W    = 8,
  parameter int DIV_LOG2 = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [LEN_W-1:0]       cfg_len,
  input  logic [1:0]             cfg_mode,
  input  logic                   poke,
  output logic [LEN_W+LOW_W-1:0] cnt_o,
  output logic                   irq_o,
  output logic                   nmi_o,
  output logic                   srst_o
);
  logic [LEN_W-1:0] len_q;
  logic [1:0]       mode_q;
  logic [LEN_W-1:0] src_len;
  logic             enabled;
  logic             load;
  logic             tick;
  logic             expire;
  wdg_stage_e       stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      mode_q <= 2'd0;
    end else if (cfg_we) begin
      len_q  <= cfg_len;
      mode_q <= cfg_mode;
    end
  end

  assign enabled = mode_enabled(mode_q);
  assign load    = cfg_we || poke;
  assign src_len = cfg_we ? cfg_len : len_q;

  wdg_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enabled),
    .restart (load),
    .tick    (tick)
  );

  wdg_downcount #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .src_len (src_len),
    .tick    (tick),
    .cnt     (cnt_o),
    .expire  (expire)
  );

  wdg_escalate u_stg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (load),
    .expire    (expire),
    .mode      (mode_q),
    .stage     (stage),
    .irq_pulse (irq_o)
  );

  assign nmi_o  = (stage == STG_NMI) || (stage == STG_RST);
  assign srst_o = (stage == STG_RST);
endmodule

// File: rtl/wdg_escalator_chk.sv
module wdg_escalator_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [1:0]       mode_q,
  input logic             tick,
  input logic             expire,
  input logic [CNT_W-1:0] cnt_o,
  input logic             irq_o,
  input logic             nmi_o,
  input logic             srst_o
);
  // R4
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R6
  srst_needs_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |-> nmi_o);

  // R5
  nmi_rise_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(expire));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd0 && !tick && !load) |=> $stable(cnt_o));

  // R8
  poke_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!nmi_o && !srst_o && !irq_o));

  // R7
  mode1_no_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1) |-> !nmi_o);

  // R7
  mode2_no_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> !srst_o);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> (!irq_o && !nmi_o && !srst_o && !tick));
endmodule

bind wdg_escalator wdg_escalator_chk #(.CNT_W(LEN_W + LOW_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load   (load),
  .mode_q (mode_q),
  .tick   (tick),
  .expire (expire),
  .cnt_o  (cnt_o),
  .irq_o  (irq_o),
  .nmi_o  (nmi_o),
  .srst_o (srst_o)
);

// File: tb/tb_wdg_escalator.sv
module tb_wdg_escalator;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;
  localparam int LOW_W      = 2;
  localparam int DIV_LOG2   = 2;
  localparam int NDIV       = 1 << DIV_LOG2;
  localparam int CNT_W      = LEN_W + LOW_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [1:0]       cfg_mode = 2'd0;
  logic             poke = 1'b0;
  logic [CNT_W-1:0] cnt_o;
  logic             irq_o, nmi_o, srst_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_escalator #(.LEN_W(LEN_W), .LOW_W(LOW_W), .DIV_LOG2(DIV_LOG2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_mode(cfg_mode), .poke(poke), .cnt_o(cnt_o), .irq_o(irq_o),
    .nmi_o(nmi_o), .srst_o(srst_o)
  );

  typedef struct packed {
    logic [15:0] len;
    logic [1:0]  mode;
    logic [31:0] wait_cyc;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{16'd3, 2'd3, 32'd0},
    '{16'd3, 2'd3, 32'd3},
    '{16'd3, 2'd3, 32'd4},
    '{16'd3, 2'd3, 32'd51},
    '{16'd3, 2'd3, 32'd52},
    '{16'd3, 2'd3, 32'd53},
    '{16'd3, 2'd3, 32'd104},
    '{16'd3, 2'd3, 32'd156},
    '{16'd3, 2'd1, 32'd160},
    '{16'd3, 2'd2, 32'd160},
    '{16'd1, 2'd3, 32'd61},
    '{16'd0, 2'd3, 32'd4},
    '{16'd0, 2'd3, 32'd12},
    '{16'd3, 2'd0, 32'd200}
  };

  function automatic int model_reload(input int len);
    return len * (1 << LOW_W);
  endfunction

  function automatic int model_cnt(input int len, input int mode, input int w);
    int r, k;
    r = model_reload(len);
    if (mode == 0) return r;
    k = w / NDIV;
    return r - (k % (r + 1));
  endfunction

  function automatic int model_stage(input int len, input int mode, input int w);
    int r, e;
    r = model_reload(len);
    e = (w / NDIV) / (r + 1);
    return (e < mode) ? e : mode;
  endfunction

  function automatic int model_irq(input int len, input int mode, input int w);
    return (mode != 0 && w == (model_reload(len) + 1) * NDIV) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic write_cfg(input int len, input int mode);
    @(negedge clk);
    cfg_we = 1'b1; cfg_len = LEN_W'(len); cfg_mode = 2'(mode);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_poke();
    @(negedge clk);
    poke = 1'b1;
    @(posedge clk);
    @(negedge clk);
    poke = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int st, irq_count;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 nmi", int'(nmi_o), 0);
    check("R1 srst", int'(srst_o), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      write_cfg(int'(VEC[i].len), int'(VEC[i].mode));
      repeat (int'(VEC[i].wait_cyc)) @(negedge clk);
      st = model_stage(int'(VEC[i].len), int'(VEC[i].mode), int'(VEC[i].wait_cyc));
      check("R3 cnt", int'(cnt_o),
            model_cnt(int'(VEC[i].len), int'(VEC[i].mode), int'(VEC[i].wait_cyc)));
      check("R4 irq", int'(irq_o),
            model_irq(int'(VEC[i].len), int'(VEC[i].mode), int'(VEC[i].wait_cyc)));
      check("R5 R7 nmi", int'(nmi_o), (st >= 2) ? 1 : 0);
      check("R6 R7 srst", int'(srst_o), (st == 3) ? 1 : 0);
    end

    // R2 widest length readback, timer disabled
    write_cfg(16'hFFFF, 0);
    check("R2 max len", int'(cnt_o), 32'hFFFF * (1 << LOW_W));

    // R8 poke after full escalation
    write_cfg(1, 3);
    repeat (61) @(negedge clk);
    check("R6 srst before poke", int'(srst_o), 1);
    do_poke();
    check("R8 nmi cleared", int'(nmi_o), 0);
    check("R8 srst cleared", int'(srst_o), 0);
    check("R8 cnt reload", int'(cnt_o), 4);
    repeat (NDIV - 1) @(negedge clk);
    check("R8 prescaler restart hold", int'(cnt_o), 4);
    @(negedge clk);
    check("R8 first tick", int'(cnt_o), 3);

    // R4 only one interrupt pulse over several expiries
    write_cfg(0, 3);
    irq_count = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (irq_o) irq_count++;
    end
    check("R4 pulse count", irq_count, 1);

    // R9 poke while disabled has no visible effect
    write_cfg(3, 0);
    do_poke();
    repeat (300) @(negedge clk);
    check("R9 cnt frozen", int'(cnt_o), 12);
    check("R9 irq", int'(irq_o), 0);
    check("R9 nmi", int'(nmi_o), 0);
    check("R9 srst", int'(srst_o), 0);

    report();
  end
endmodule